// File: doc/BRIEF.md
# Hybrid Class-Based Bus Arbiter

This block is the central arbiter of a shared system bus. Bus masters sit in four request classes. Each class presents one request line to the arbiter, formed as the OR of its members' requests. The arbiter returns one grant line per class. Inside a class the grant runs down a serial chain. The first requesting master on the chain takes the grant, and every master ahead of it that is not requesting hands it on.

Between classes the arbiter applies one of two policies, chosen by a mode input. Fixed priority always prefers the highest class. Rotating priority demotes the class that just won to last place for the next decision. Release is non-preemptive: the owner keeps its grant for as long as it reports the bus busy. In fixed-priority mode the arbiter drives an active-low bus-clear line whenever a higher class is waiting, so the owner can finish early. The arbiter only ever offers the bus after the busy indication has dropped.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: With `rotate_mode`=0, the winning class is the highest-numbered class with a request: class 3 beats class 2, class 2 beats class 1, and class 1 beats class 0.
- R2: With `rotate_mode`=1, the class granted last becomes the lowest priority. Priority then descends from the class numbered one below it, wrapping modulo 4. With every class requesting, the grant order is 3, 2, 1, 0, 3.
- R3: Class c holds masters at `mst_req`/`mst_gnt` bits c*3+0 (first on the chain) through c*3+2. The class grant goes to the lowest-indexed requesting master of that class.
- R4: At most one bit of `cls_gnt` is high at any time, and at most one bit of `mst_gnt` is high.
- R5: A grant is issued on the clock edge after the arbiter sees a class request while idle, but only if `bus_busy` is low at that edge. Once `bus_busy` has risen, the grant is held unchanged, whatever happens to the requests. The grant drops on the edge at which `bus_busy` is seen low.
- R6: With `rotate_mode`=0, `bus_clr_n` goes low on the edge after a request is seen from a class above the current owner. With `rotate_mode`=1 it is never driven low.
- R7: `bus_clr_n` returns high on the same edge that issues the next grant, or at an idle edge where no class is requesting.
- R8: No grant is issued to a class that is not requesting. If a granted class drops its request before `bus_busy` rises, its grant is withdrawn on the next edge.
- R9: During and after reset, all grants are low, `bus_clr_n` is high, and rotating priority starts with class 3 on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rotate_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| mst_req | input | 12 | Per-master request, class c at bits c*3..c*3+2 |
| bus_busy | input | 1 | High while the owner is using the bus |
| cls_gnt | output | 4 | Grant line per class |
| mst_gnt | output | 12 | Grant per master after the in-class chain |
| bus_clr_n | output | 1 | Active-low request for the owner to release early |

## Verification
Every cycle, the assertions check four things:
- grants stay one-hot;
- a new grant always traces back to a request and to an idle bus;
- a held grant stays stable while the bus is busy;
- bus-clear falls only in fixed mode.

Only the bench scenarios can show that the right class wins: the strict rotation order, fixed-priority selection with mixed requests, and the chain choosing the first requester. They also show that bus-clear falls and recovers at the right edges, and that a grant is withdrawn when its request is taken back.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HOLD  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/hba_pick.sv
module hba_pick #(
    parameter int NUM_CLASSES = 4,
    parameter int CLS_W       = 2
) (
    input  logic [NUM_CLASSES-1:0] req,
    input  logic                   rotate,
    input  logic [CLS_W-1:0]       last,
    output logic [CLS_W-1:0]       winner,
    output logic                   any
);
    int start_idx;
    always_comb begin
        winner = '0;
        any    = 1'b0;
        if (rotate) begin
            start_idx = (int'(last) == 0) ? NUM_CLASSES - 1 : int'(last) - 1;
        end else begin
            start_idx = NUM_CLASSES - 1;
        end
        for (int k = 0; k < NUM_CLASSES; k++) begin
            int j;
            j = start_idx - k;
            if (j < 0) j = j + NUM_CLASSES;
            if (!any && req[j]) begin
                any    = 1'b1;
                winner = CLS_W'(j);
            end
        end
    end
endmodule

// File: rtl/hba_above.sv
module hba_above #(
    parameter int NUM_CLASSES = 4,
    parameter int CLS_W       = 2
) (
    input  logic [NUM_CLASSES-1:0] req,
    input  logic [CLS_W-1:0]       owner,
    output logic                   pending
);
    always_comb begin
        pending = 1'b0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (req[c] && (c > int'(owner))) pending = 1'b1;
        end
    end
endmodule

// File: rtl/hba_chain.sv
module hba_chain #(
    parameter int MASTERS = 3
) (
    input  logic               gnt_in,
    input  logic [MASTERS-1:0] req,
    output logic [MASTERS-1:0] gnt
);
    logic [MASTERS:0] pass;
    assign pass[0] = gnt_in;
    for (genvar i = 0; i < MASTERS; i++) begin : g_link
        assign gnt[i]    = pass[i] & req[i];
        assign pass[i+1] = pass[i] & ~req[i];
    end
endmodule

// File: rtl/hybrid_bus_arbiter.sv
module hybrid_bus_arbiter #(
    parameter int NUM_CLASSES       = 4,
    parameter int MASTERS_PER_CLASS = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     rotate_mode,
    input  logic [NUM_CLASSES*MASTERS_PER_CLASS-1:0] mst_req,
    input  logic                                     bus_busy,
    output logic [NUM_CLASSES-1:0]                   cls_gnt,
    output logic [NUM_CLASSES*MASTERS_PER_CLASS-1:0] mst_gnt,
    output logic                                     bus_clr_n
);
    import hba_pkg::*;

    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1;
    localparam int MPC   = MASTERS_PER_CLASS;

    typedef struct packed {
        arb_state_e             st;
        logic [NUM_CLASSES-1:0] gnt;
        logic [CLS_W-1:0]       owner;
        logic [CLS_W-1:0]       last;
        logic                   clr_n;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [NUM_CLASSES-1:0] cls_req;
    logic [CLS_W-1:0]       win_idx;
    logic                   any_req;
    logic                   above_pend;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        assign cls_req[c] = |mst_req[c*MPC +: MPC];
        hba_chain #(.MASTERS(MPC)) u_chain (
            .gnt_in (r_q.gnt[c]),
            .req    (mst_req[c*MPC +: MPC]),
            .gnt    (mst_gnt[c*MPC +: MPC])
        );
    end

    hba_pick #(.NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W)) u_pick (
        .req    (cls_req),
        .rotate (rotate_mode),
        .last   (r_q.last),
        .winner (win_idx),
        .any    (any_req)
    );

    hba_above #(.NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W)) u_above (
        .req     (cls_req),
        .owner   (r_q.owner),
        .pending (above_pend)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (any_req && !bus_busy) begin
                    r_d.st    = ST_OFFER;
                    r_d.gnt   = NUM_CLASSES'(1) << win_idx;
                    r_d.owner = win_idx;
                    r_d.last  = win_idx;
                    r_d.clr_n = 1'b1;
                end else if (!any_req) begin
                    r_d.clr_n = 1'b1;
                end
            end
            ST_OFFER: begin
                if (!rotate_mode && above_pend) r_d.clr_n = 1'b0;
                if (bus_busy) begin
                    r_d.st = ST_HOLD;
                end else if (!cls_req[r_q.owner]) begin
                    r_d.st  = ST_IDLE;
                    r_d.gnt = '0;
                end
            end
            ST_HOLD: begin
                if (!rotate_mode && above_pend) r_d.clr_n = 1'b0;
                if (!bus_busy) begin
                    r_d.st  = ST_IDLE;
                    r_d.gnt = '0;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.gnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.gnt   <= '0;
            r_q.owner <= '0;
            r_q.last  <= '0;
            r_q.clr_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cls_gnt   = r_q.gnt;
    assign bus_clr_n = r_q.clr_n;

    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_gnt) && $onehot0(mst_gnt));

    p_master_in_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_gnt != '0) |-> (cls_gnt != '0));

    p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_gnt != '0 && $past(cls_gnt) == '0) |-> (($past(cls_req) & cls_gnt) != '0));

    p_grant_after_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_gnt != '0 && $past(cls_gnt) == '0) |-> !$past(bus_busy));

    p_hold_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && bus_busy) |=> $stable(cls_gnt));

    p_clear_fixed_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_clr_n) |-> !$past(rotate_mode));
endmodule

// File: tb/sim_hybrid_bus_arbiter.sv
module sim_hybrid_bus_arbiter;
    localparam int NC  = 4;
    localparam int MPC = 3;
    localparam int NM  = NC * MPC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rotate_mode = 1'b0;
    logic [NM-1:0] mst_req = '0;
    logic          bus_busy = 1'b0;
    logic [NC-1:0] cls_gnt;
    logic [NM-1:0] mst_gnt;
    logic          bus_clr_n;

    int total = 0;
    int bad = 0;
    string cur_tag = "R9";
    bit auto_own = 1'b0;
    int txn_len = 3;
    int own_cnt = 0;

    int m_st = 0, m_g = -1, m_last = 0, m_clr = 1;

    always #10 clk = ~clk;

    hybrid_bus_arbiter #(.NUM_CLASSES(NC), .MASTERS_PER_CLASS(MPC)) u0 (
        .clk(clk), .rst_n(rst_n), .rotate_mode(rotate_mode), .mst_req(mst_req),
        .bus_busy(bus_busy), .cls_gnt(cls_gnt), .mst_gnt(mst_gnt), .bus_clr_n(bus_clr_n)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit creq(int c);
        return |mst_req[c*MPC +: MPC];
    endfunction

    function automatic int model_pick(bit rot, int last);
        for (int s = 1; s <= NC; s++) begin
            int c;
            c = rot ? ((last - s + 2 * NC) % NC) : (NC - s);
            if (creq(c)) return c;
        end
        return -1;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_g = -1; m_last = 0; m_clr = 1;
        end else begin
            bit higher;
            higher = 1'b0;
            if (m_g >= 0)
                for (int c = m_g + 1; c < NC; c++) if (creq(c)) higher = 1'b1;
            if (m_st == 0) begin
                int w;
                w = model_pick(rotate_mode, m_last);
                if (w >= 0 && !bus_busy) begin
                    m_st = 1; m_g = w; m_last = w; m_clr = 1;
                end else if (w < 0) begin
                    m_clr = 1;
                end
            end else begin
                if (!rotate_mode && higher) m_clr = 0;
                if (m_st == 1) begin
                    if (bus_busy) m_st = 2;
                    else if (!creq(m_g)) begin m_st = 0; m_g = -1; end
                end else if (!bus_busy) begin
                    m_st = 0; m_g = -1;
                end
            end
        end
    end

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NC-1:0] e_cls;
            logic [NM-1:0] e_mst;
            e_cls = '0;
            e_mst = '0;
            if (m_g >= 0) begin
                e_cls[m_g] = 1'b1;
                for (int m = MPC - 1; m >= 0; m--)
                    if (mst_req[m_g*MPC + m]) begin
                        e_mst = '0;
                        e_mst[m_g*MPC + m] = 1'b1;
                    end
            end
            chk(cls_gnt == e_cls, cur_tag, "cls_gnt", int'(cls_gnt), int'(e_cls));
            chk(mst_gnt == e_mst, cur_tag, "mst_gnt", int'(mst_gnt), int'(e_mst));
            chk(bus_clr_n == m_clr[0], cur_tag, "bus_clr_n", int'(bus_clr_n), m_clr);
        end
    end

    // Behavioural bus owner
    always @(posedge clk) begin
        #3;
        if (auto_own) begin
            if (bus_busy) begin
                own_cnt--;
                if (own_cnt <= 0) bus_busy = 1'b0;
            end else if (cls_gnt != '0) begin
                bus_busy = 1'b1;
                own_cnt = txn_len;
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_gnt(int c, string tag);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (cls_gnt[c]) seen = 1'b1;
        end
        chk(seen, tag, "grant to class", int'(cls_gnt), 1 << c);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(cls_gnt == '0, "R9", "cls_gnt in reset", int'(cls_gnt), 0);
        chk(bus_clr_n == 1'b1, "R9", "bus_clr_n in reset", int'(bus_clr_n), 1);
        step(1);
        rst_n = 1'b1;
        step(2);
        chk(mst_gnt == '0, "R9", "mst_gnt after reset", int'(mst_gnt), 0);

        // R1 fixed priority: classes 0 and 2
        cur_tag = "R1";
        auto_own = 1'b1; txn_len = 3;
        mst_req[0] = 1'b1; mst_req[6] = 1'b1;
        wait_gnt(2, "R1");
        step(1); mst_req[6] = 1'b0;
        wait_gnt(0, "R1");
        step(1); mst_req[0] = 1'b0;
        step(8);

        // R3 chain: class 1 masters 1 and 2
        cur_tag = "R3";
        mst_req[4] = 1'b1; mst_req[5] = 1'b1;
        wait_gnt(1, "R3");
        chk(mst_gnt == NM'(1) << 4, "R3", "chain picks first requester", int'(mst_gnt), 16);
        step(1); mst_req[4] = 1'b0; mst_req[5] = 1'b0;
        step(8);

        // R2 rotating order, all classes requesting
        cur_tag = "R2";
        rotate_mode = 1'b1; txn_len = 2;
        mst_req[0] = 1'b1; mst_req[3] = 1'b1; mst_req[6] = 1'b1; mst_req[9] = 1'b1;
        wait_gnt(3, "R2");
        wait_gnt(2, "R2");
        wait_gnt(1, "R2");
        wait_gnt(0, "R2");
        chk($countones(cls_gnt) <= 1, "R4", "single class grant", $countones(cls_gnt), 1);
        wait_gnt(3, "R2");
        step(1);
        mst_req = '0;
        step(10);

        // R6 / R7 fixed mode bus-clear
        cur_tag = "R6";
        rotate_mode = 1'b0; txn_len = 10;
        mst_req[1] = 1'b1;
        wait_gnt(0, "R6");
        step(1); mst_req[1] = 1'b0;
        mst_req[11] = 1'b1;
        step(1);
        @(negedge clk);
        chk(bus_clr_n == 1'b0, "R6", "clear asserted for higher class", int'(bus_clr_n), 0);
        cur_tag = "R7";
        wait_gnt(3, "R7");
        chk(bus_clr_n == 1'b1, "R7", "clear released with new grant", int'(bus_clr_n), 1);
        step(1); mst_req[11] = 1'b0;
        step(14);

        // R6 rotating mode never clears
        cur_tag = "R6";
        rotate_mode = 1'b1; txn_len = 8;
        mst_req[2] = 1'b1;
        wait_gnt(0, "R6");
        step(1); mst_req[2] = 1'b0;
        mst_req[9] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(bus_clr_n == 1'b1, "R6", "no clear in rotating mode", int'(bus_clr_n), 1);
        end
        wait_gnt(3, "R6");
        step(1); mst_req[9] = 1'b0;
        step(12);

        // R8 withdrawn request
        cur_tag = "R8";
        auto_own = 1'b0;
        step(2);
        bus_busy = 1'b0;
        rotate_mode = 1'b0;
        mst_req[5] = 1'b1;
        wait_gnt(1, "R8");
        chk(mst_gnt == NM'(1) << 5, "R8", "master 5 granted", int'(mst_gnt), 32);
        step(1); mst_req[5] = 1'b0;
        step(1);
        @(negedge clk);
        chk(cls_gnt == '0, "R8", "grant withdrawn", int'(cls_gnt), 0);

        // R5 busy bus blocks new grants; held grant while busy
        cur_tag = "R5";
        step(1);
        bus_busy = 1'b1;
        mst_req[7] = 1'b1;
        step(5);
        @(negedge clk);
        chk(cls_gnt == '0, "R5", "no grant while bus busy", int'(cls_gnt), 0);
        step(1); bus_busy = 1'b0;
        wait_gnt(2, "R5");
        step(1); bus_busy = 1'b1;
        step(1); mst_req[7] = 1'b0;
        step(3);
        @(negedge clk);
        chk(cls_gnt == 4'b0100, "R5", "grant held while busy", int'(cls_gnt), 4);
        step(1); bus_busy = 1'b0;
        step(1);
        @(negedge clk);
        chk(cls_gnt == '0, "R5", "grant dropped after busy falls", int'(cls_gnt), 0);
        step(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule